// File: doc/BRIEF.md
# Interpolating Second-Order Delta-Sigma Bit Modulator

The block turns a stream of 32-bit signed audio samples into a one-bit pulse-density stream at 512 times the sample rate. Its front end interpolates linearly between the previous sample and the newest one. That gives a straight ramp of 512 points per sample period, and the ramp ends exactly on the new value. The back end is a two-integrator noise-shaping loop with 48-bit accumulators and a one-bit quantizer. Its output bit drives an external analog reconstruction filter.

The block paces its own input. In the last modulator step of every window it raises a one-cycle request. The upstream source presents the next sample with valid high in that same cycle. If valid is low, the block keeps the previous sample, so the ramp for the next window stays flat.

Top module: `dsm2_interp_dac`

## Requirements
- R1: While reset is asserted, `req_o` is 0, `interp_o` is 0 and `bit_o` is 1.
- R2: `req_o` is high for exactly one cycle in every 2^OSR_LOG2 cycles. The first pulse comes in the 2^OSR_LOG2-th cycle after reset is released, and it marks the last step of a window.
- R3: A sample is taken only at the clock edge that ends a cycle in which both `req_o` and `valid_i` are high. `valid_i` and `sample_i` in any other cycle have no effect on `interp_o`.
- R4: At the first step of the window that follows acceptance of x[n], `interp_o` equals x[n-1] exactly. After reset, x[-1] is 0.
- R5: At step s (0 to 2^OSR_LOG2-1) of that window, `interp_o` equals floor(x[n-1] + s*(x[n]-x[n-1]) / 2^OSR_LOG2). This is the slope (x[n]-x[n-1])/512 carried with OSR_LOG2 fraction bits.
- R6: If `valid_i` is low during a request, the last accepted sample is used again, and `interp_o` stays constant through the whole next window.
- R7: `bit_o` is 1 when the second integrator is non-negative. The value fed back is plus or minus 2^(SAMPLE_W-1+OSR_LOG2), which is full scale in accumulator units. For a constant input x held for a window, the number of ones in that window is within 4 of 2^OSR_LOG2 * (x + 2^31) / 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Modulator clock, one output bit per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 32 | Signed input sample, two's complement |
| valid_i | input | 1 | Qualifies `sample_i` while `req_o` is high |
| req_o | output | 1 | Request for the next sample, high in the last step of a window |
| interp_o | output | 32 | Integer part of the interpolated ramp that feeds the loop |
| bit_o | output | 1 | One-bit modulator output |

## Verification
The bench builds the block with its default values: 32-bit samples, 48-bit integrators and a window of 512 steps. At this size a jump from the most positive to the most negative sample can be checked, which shows that the ramp lands exactly on the target even when the difference uses all 33 bits. At 512 steps, the ones counted over one window resolve the pulse density finely enough to test it against constant inputs of either sign. Shortened windows would hide an off-by-one in the slope shift. The full window shows it as a missed landing value.

// File: rtl/dsm2_pkg.sv
package dsm2_pkg;
  localparam int unsigned DEF_SAMPLE_W = 32;
  localparam int unsigned DEF_ACC_W    = 48;
  localparam int unsigned DEF_OSR_LOG2 = 9;

  function automatic int unsigned ramp_width(int unsigned sample_w, int unsigned osr_log2);
    return sample_w + osr_log2;
  endfunction
endpackage

// File: rtl/dsm_step_timer.sv
module dsm_step_timer #(
  parameter int unsigned OSR_LOG2 = dsm2_pkg::DEF_OSR_LOG2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic last_o
);
  logic [OSR_LOG2-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = &cnt_q;

  p_single_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !last_o);
  p_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> (cnt_q == '0));
endmodule

// File: rtl/dsm_interp_ramp.sv
module dsm_interp_ramp #(
  parameter int unsigned SAMPLE_W = dsm2_pkg::DEF_SAMPLE_W,
  parameter int unsigned OSR_LOG2 = dsm2_pkg::DEF_OSR_LOG2,
  localparam int unsigned RAMP_W  = dsm2_pkg::ramp_width(SAMPLE_W, OSR_LOG2)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                last_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                valid_i,
  output logic [RAMP_W-1:0]   ramp_o,
  output logic [SAMPLE_W-1:0] interp_o
);
  localparam int unsigned EXT_W = RAMP_W - SAMPLE_W - 1;

  logic [SAMPLE_W-1:0] target_q, next_tgt;
  logic [SAMPLE_W:0]   slope_q, diff;   // step size with OSR_LOG2 fraction bits
  logic [RAMP_W-1:0]   ramp_q, ramp_sum, slope_ext;

  assign next_tgt  = (last_i && valid_i) ? sample_i : target_q;
  assign diff      = {next_tgt[SAMPLE_W-1], next_tgt} - {target_q[SAMPLE_W-1], target_q};
  assign slope_ext = {{EXT_W{slope_q[SAMPLE_W]}}, slope_q};
  assign ramp_sum  = ramp_q + slope_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      target_q <= '0;
      slope_q  <= '0;
      ramp_q   <= '0;
    end else begin
      ramp_q <= ramp_sum;
      if (last_i) begin
        target_q <= next_tgt;
        slope_q  <= diff;
      end
    end
  end

  assign ramp_o   = ramp_q;
  assign interp_o = ramp_q[RAMP_W-1 -: SAMPLE_W];

  // ramp must arrive on the held target after a full window
  p_ramp_lands_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_i |-> (ramp_sum == {target_q, {OSR_LOG2{1'b0}}}));
  p_accept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_i && valid_i) |=> (target_q == $past(sample_i)));
  p_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_i |=> ($stable(target_q) && $stable(slope_q)));
  p_hold_flat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_i && !valid_i) |=> (slope_q == '0));
endmodule

// File: rtl/dsm2_loop.sv
module dsm2_loop #(
  parameter int unsigned IN_W     = 41,
  parameter int unsigned ACC_W    = dsm2_pkg::DEF_ACC_W,
  localparam int unsigned FS_SHIFT = IN_W - 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [IN_W-1:0] u_i,
  output logic            bit_o
);
  localparam logic signed [ACC_W-1:0] FULL_SCALE = ACC_W'(1) <<< FS_SHIFT;

  logic signed [ACC_W-1:0] i1_q, i2_q, i1_n, i2_n, u_ext, fb;

  assign u_ext = {{(ACC_W-IN_W){u_i[IN_W-1]}}, u_i};
  assign bit_o = ~i2_q[ACC_W-1];
  assign fb    = bit_o ? FULL_SCALE : -FULL_SCALE;
  assign i1_n  = i1_q + u_ext - fb;
  assign i2_n  = i2_q + i1_n - fb;   // uses the fresh first-integrator value

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      i1_q <= '0;
      i2_q <= '0;
    end else begin
      i1_q <= i1_n;
      i2_q <= i2_n;
    end
  end

  // first integrator moves toward the input, away from the emitted level
  p_fb_dir_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_o && !u_ext[ACC_W-1] && (u_ext < FULL_SCALE)) |=> (i1_q < $past(i1_q)));
endmodule

// File: rtl/dsm2_interp_dac.sv
module dsm2_interp_dac #(
  parameter int unsigned SAMPLE_W = dsm2_pkg::DEF_SAMPLE_W,
  parameter int unsigned ACC_W    = dsm2_pkg::DEF_ACC_W,
  parameter int unsigned OSR_LOG2 = dsm2_pkg::DEF_OSR_LOG2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                valid_i,
  output logic                req_o,
  output logic [SAMPLE_W-1:0] interp_o,
  output logic                bit_o
);
  localparam int unsigned RAMP_W = dsm2_pkg::ramp_width(SAMPLE_W, OSR_LOG2);

  logic              last;
  logic [RAMP_W-1:0] ramp;

  dsm_step_timer #(.OSR_LOG2(OSR_LOG2)) u_timer (
    .clk_i (clk_i), .rst_ni (rst_ni), .last_o (last)
  );

  dsm_interp_ramp #(.SAMPLE_W(SAMPLE_W), .OSR_LOG2(OSR_LOG2)) u_ramp (
    .clk_i (clk_i), .rst_ni (rst_ni), .last_i (last),
    .sample_i (sample_i), .valid_i (valid_i),
    .ramp_o (ramp), .interp_o (interp_o)
  );

  dsm2_loop #(.IN_W(RAMP_W), .ACC_W(ACC_W)) u_loop (
    .clk_i (clk_i), .rst_ni (rst_ni), .u_i (ramp), .bit_o (bit_o)
  );

  assign req_o = last;

  p_reset_r1: assert property (@(posedge clk_i) !rst_ni |-> (!req_o && bit_o));
endmodule

// File: tb/dsm2_interp_dac_test.sv
`timescale 1ns/1ps
module dsm2_interp_dac_test;
  localparam int L   = 9;
  localparam int OSR = 1 << L;

  typedef struct { longint o; longint n; } pair_t;

  logic        clk_i = 0, rst_ni = 0, valid_i = 0;
  logic [31:0] sample_i = '0;
  logic        req_o, bit_o;
  logic [31:0] interp_o;

  int n_chk = 0, n_fail = 0;
  bit started = 0, done = 0, dens_en = 1, finished = 0;
  pair_t q[$];
  longint tgt = 0;
  int unsigned junk_ctr = 0;

  always #5 clk_i = ~clk_i;

  dsm2_interp_dac uut (
    .clk_i, .rst_ni, .sample_i, .valid_i, .req_o, .interp_o, .bit_o
  );

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // driver: one call per window, pushes the expected ramp end points
  task automatic run_window(input logic [31:0] v, input bit vld, input bit junk);
    forever begin
      @(negedge clk_i);
      if (req_o) begin
        valid_i  = vld;
        sample_i = v;
        q.push_back('{tgt, vld ? longint'($signed(v)) : tgt});
        if (vld) tgt = longint'($signed(v));
        break;
      end else begin
        junk_ctr++;
        valid_i  = junk;
        sample_i = junk ? (32'h5A5A_0000 ^ junk_ctr) : 32'h0;
      end
    end
  endtask

  // monitor: pops a pair at each window start and compares the ramp and density
  pair_t  cur = '{0, 0};
  int     s = 0, ones = 0;
  longint k = 0, next_req = OSR - 1;
  bit     prev_req = 0;

  always @(negedge clk_i) begin
    if (started && !done) begin
      if (prev_req) begin
        if (q.size() == 0) chk(0, "R4 queue", 0, 1);
        else cur = q.pop_front();
        s = 0;
        ones = 0;
      end else if (k != 0) s++;
      ones += int'(bit_o);
      if (s == 0 || s == OSR/2 || s == OSR-1) begin
        longint e;
        e = ((cur.o <<< L) + longint'(s) * (cur.n - cur.o)) >>> L;
        if (s == 0) chk(longint'($signed(interp_o)) == e, "R4 window start", $signed(interp_o), e);
        else if (cur.o == cur.n) chk(longint'($signed(interp_o)) == e, "R6 flat ramp", $signed(interp_o), e);
        else chk(longint'($signed(interp_o)) == e, "R5 ramp step", $signed(interp_o), e);
      end
      if (s == OSR-1 && dens_en && cur.o == cur.n) begin
        longint exp_ones;
        exp_ones = ((cur.o + 64'sd2147483648) * OSR) >>> 32;
        chk((ones - exp_ones <= 4) && (exp_ones - ones <= 4), "R7 density", ones, exp_ones);
      end
      if (k == next_req) begin
        chk(req_o == 1'b1, "R2 request period", req_o, 1);
        next_req += OSR;
      end else if (req_o) chk(0, "R2 stray request", k, next_req);
      prev_req = req_o;
      k++;
    end
  end

  initial begin
    #2_000_000;
    chk(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(req_o == 1'b0, "R1 req", req_o, 0);
    chk(interp_o == 32'h0, "R1 interp", interp_o, 0);
    chk(bit_o == 1'b1, "R1 bit", bit_o, 1);
    @(posedge clk_i);
    #2 rst_ni = 1;
    started = 1;
    // R7 constant positive input, R3 junk valid outside requests
    repeat (3) run_window(32'h1000_0000, 1, 1);
    repeat (3) run_window(32'hE000_0000, 1, 1);
    // R6 missing samples repeat the last one
    repeat (2) run_window(32'h1234_5678, 0, 1);
    run_window(32'h0000_3039, 1, 0);
    run_window(32'hFFFF_FCF7, 1, 1);
    repeat (2) run_window(32'h0000_0000, 1, 0);
    dens_en = 0;
    // full-range swings check exact landing (R4, R5)
    run_window(32'h7FFF_FFFF, 1, 0);
    run_window(32'h8000_0000, 1, 0);
    run_window(32'h7FFF_FFFF, 1, 1);
    run_window(32'h0000_0000, 0, 0);
    repeat (OSR - 1) @(negedge clk_i);
    done = 1;
    summary();
  end
endmodule